// File: doc/BRIEF.md
# Comparator Change-Interrupt Controller

This block watches the digital results of two analog comparators and raises an interrupt flag when either result moves. Each comparator result passes through a two-flop synchronizer. The block keeps a snapshot of both synchronized results and compares the live values with that snapshot on every cycle. Whenever the two differ, the flag is set. Software ends the condition by touching the control register: any read or any write of that register loads the snapshot with the current results. After that, the flag can be cleared.

The CPU reaches four byte-wide registers over a simple bus made of an address, a read strobe, a write strobe and write data. Read data returns in the same cycle as the read strobe. The control register holds a 3-bit mode field and the two output bits. Three further registers hold the flag, the interrupt gating bits and the comparator interrupt enable.

The block drives an interrupt request and a wake-up request. It also drives one power-down line for each comparator. Two mode codes switch the comparators off: code 000 is the reset mode and code 111 is the off mode. In both codes the comparators are powered down, their outputs read as 0 and no change is detected.

Top module: `cmpchg_ctrl`

## Requirements
- R1: A change on a comparator input reaches the compare after two clock edges. The flag is set at the third rising edge after the input changes, and not before.
- R2: Reading address 0 returns the comparator outputs in bits 7:6 (comparator 1 in bit 7, comparator 0 in bit 6) and the mode in bits 2:0. Bits 5:3 read as 0. A write to address 0 sets the mode from wrData[2:0].
- R3: Any read or write of address 0 loads the snapshot with the current outputs. Once the snapshot matches the outputs, writing 0 to the flag (address 1, bit 0) clears it.
- R4: While the outputs differ from the snapshot, a software clear of the flag has no lasting effect, and the flag reads back as 1.
- R5: Writing 1 to the flag sets it even when there is no mismatch. Reading address 1 returns the flag in bit 0.
- R6: irqReq is 1 only when all four of these are 1: the flag, the comparator interrupt enable (address 3, bit 0), the peripheral enable (address 2, bit 6) and the global enable (address 2, bit 7). The flag still sets while any of these enables is 0.
- R7: Reset sets the mode to 000, clears the flag, the snapshot and all enables, and powers down both comparators.
- R8: In mode 000 or 111, both power-down lines are 1, the outputs read as 0, and no mismatch sets the flag.
- R9: wakeReq is 1 when all of these hold: sleepMode is 1, the flag is 1, the comparator interrupt enable is 1, the peripheral enable is 1, and the mode is active. wakeReq does not depend on the global enable.
- R10: Entering or leaving sleep changes no register contents.
- R11: If a mismatch and a software write of 0 to the flag occur in the same cycle, the flag ends the cycle set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register address |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, valid in the same cycle as rdEn, 0 when rdEn is low |
| cmpRaw | input | 2 | Asynchronous comparator results |
| sleepMode | input | 1 | The device is asleep |
| irqReq | output | 1 | Interrupt request |
| wakeReq | output | 1 | Wake-up request |
| cmpPowerDown | output | 2 | Power-down line for each comparator |

## Verification
The assertions check these relations on every cycle:
- A mismatch sets the flag at the next edge, and the hardware set wins over a software clear in the same cycle.
- Touching the control register loads the snapshot with the outputs from that cycle.
- When the comparators are off, the flag holds unless software writes it.
- A wake-up request appears only during sleep.
- An interrupt request appears only with the global enable set.

Some behaviour only the bench scenarios can show:
- The exact latency through the synchronizer.
- The order of touching the register and then clearing the flag that finally clears it.
- That sleep leaves the register contents unchanged.
- That wake-up does not depend on the global enable.

A reference model running alongside random bus traffic compares every output on every cycle.

// File: rtl/cmpchg_pkg.sv
package cmpchg_pkg;
  localparam int DATA_W   = 8;
  localparam int ADDR_W   = 2;
  localparam int NUM_CMP  = 2;
  localparam int MODE_W   = 3;
  localparam int GIE_BIT  = 7;
  localparam int PEIE_BIT = 6;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_INTC = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_CEN  = 2'd3;

  typedef struct packed {
    logic ctrlWr;
    logic ctrlTouch;
    logic flagWr;
    logic intcWr;
    logic cenWr;
  } strobe_t;
endpackage

// File: rtl/cmpchg_sync.sv
module cmpchg_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], asyncIn[i]};
    end
    assign syncOut[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/cmpchg_regctl.sv
module cmpchg_regctl
  import cmpchg_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [MODE_W-1:0]  modeQ,
  input  logic [NUM_CMP-1:0] liveOut,
  input  logic               flagQ,
  input  logic               gieQ,
  input  logic               peieQ,
  input  logic               cieQ,
  output strobe_t            stb,
  output logic [DATA_W-1:0]  rdData
);
  always_comb begin
    stb           = '0;
    stb.ctrlWr    = wrEn && (addr == ADDR_CTRL);
    stb.ctrlTouch = (wrEn || rdEn) && (addr == ADDR_CTRL);
    stb.flagWr    = wrEn && (addr == ADDR_FLAG);
    stb.intcWr    = wrEn && (addr == ADDR_INTC);
    stb.cenWr     = wrEn && (addr == ADDR_CEN);
  end

  always_comb begin
    rdData = '0;
    if (rdEn) begin
      unique case (addr)
        ADDR_CTRL: begin
          rdData[DATA_W-1 -: NUM_CMP] = liveOut;
          rdData[MODE_W-1:0]          = modeQ;
        end
        ADDR_FLAG: rdData[0] = flagQ;
        ADDR_INTC: begin
          rdData[GIE_BIT]  = gieQ;
          rdData[PEIE_BIT] = peieQ;
        end
        default:   rdData[0] = cieQ;
      endcase
    end
  end
endmodule

// File: rtl/cmpchg_datapath.sv
module cmpchg_datapath
  import cmpchg_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [DATA_W-1:0]  wrData,
  input  logic [NUM_CMP-1:0] liveSync,
  input  logic               sleepMode,
  output logic [MODE_W-1:0]  modeQ,
  output logic [NUM_CMP-1:0] liveOut,
  output logic               flagQ,
  output logic               gieQ,
  output logic               peieQ,
  output logic               cieQ,
  output logic               irqReq,
  output logic               wakeReq,
  output logic [NUM_CMP-1:0] cmpPowerDown
);
  logic [NUM_CMP-1:0] latQ;
  logic cmpActive, mismatch;

  assign cmpActive = (modeQ != '0) && (modeQ != '1);
  assign liveOut   = cmpActive ? liveSync : '0;
  assign mismatch  = cmpActive && (liveOut != latQ);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= '0;
      latQ  <= '0;
      flagQ <= 1'b0;
      gieQ  <= 1'b0;
      peieQ <= 1'b0;
      cieQ  <= 1'b0;
    end else begin
      if (stb.ctrlWr) modeQ <= wrData[MODE_W-1:0];
      if (!cmpActive)         latQ <= '0;
      else if (stb.ctrlTouch) latQ <= liveOut;
      if (mismatch)         flagQ <= 1'b1;
      else if (stb.flagWr)  flagQ <= wrData[0];
      if (stb.intcWr) begin
        gieQ  <= wrData[GIE_BIT];
        peieQ <= wrData[PEIE_BIT];
      end
      if (stb.cenWr) cieQ <= wrData[0];
    end
  end

  assign irqReq  = flagQ && cieQ && peieQ && gieQ;
  assign wakeReq = sleepMode && cmpActive && flagQ && cieQ && peieQ;

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_pd
    assign cmpPowerDown[i] = !rstN || !cmpActive;
  end

  // R1
  mismatch_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    mismatch |=> flagQ);
  // R11
  hw_set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mismatch && stb.flagWr && !wrData[0]) |=> flagQ);
  // R3
  touch_loads_snapshot_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ctrlTouch && cmpActive) |=> (latQ == $past(liveOut)));
  // R8
  off_holds_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmpActive && !stb.flagWr) |=> $stable(flagQ));
  // R9
  wake_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rstN)
    wakeReq |-> sleepMode);
  // R6
  irq_needs_global_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> gieQ);
  // R7
  reset_mode_chk: assert property (@(posedge clk)
    !rstN |-> (modeQ == '0 && !flagQ && (&cmpPowerDown)));
endmodule

// File: rtl/cmpchg_ctrl.sv
module cmpchg_ctrl
  import cmpchg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               rdEn,
  input  logic               wrEn,
  input  logic [DATA_W-1:0]  wrData,
  output logic [DATA_W-1:0]  rdData,
  input  logic [NUM_CMP-1:0] cmpRaw,
  input  logic               sleepMode,
  output logic               irqReq,
  output logic               wakeReq,
  output logic [NUM_CMP-1:0] cmpPowerDown
);
  strobe_t            stb;
  logic [NUM_CMP-1:0] liveSync, liveOut;
  logic [MODE_W-1:0]  modeQ;
  logic               flagQ, gieQ, peieQ, cieQ;

  cmpchg_sync #(.WIDTH(NUM_CMP), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(cmpRaw), .syncOut(liveSync));

  cmpchg_regctl u_regctl (
    .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .modeQ(modeQ), .liveOut(liveOut),
    .flagQ(flagQ), .gieQ(gieQ), .peieQ(peieQ), .cieQ(cieQ),
    .stb(stb), .rdData(rdData));

  cmpchg_datapath u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .liveSync(liveSync),
    .sleepMode(sleepMode), .modeQ(modeQ), .liveOut(liveOut), .flagQ(flagQ),
    .gieQ(gieQ), .peieQ(peieQ), .cieQ(cieQ), .irqReq(irqReq),
    .wakeReq(wakeReq), .cmpPowerDown(cmpPowerDown));
endmodule

// File: tb/cmpchg_ctrl_bench.sv
module cmpchg_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b1;
  logic [1:0] addr = '0;
  logic rdEn = 1'b0, wrEn = 1'b0, sleepMode = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] cmpRaw = '0;
  logic [7:0] rdData;
  logic irqReq, wakeReq;
  logic [1:0] cmpPowerDown;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  cmpchg_ctrl u_cmpchg_ctrl (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .cmpRaw(cmpRaw), .sleepMode(sleepMode),
    .irqReq(irqReq), .wakeReq(wakeReq), .cmpPowerDown(cmpPowerDown));

  // reference model
  logic [1:0] mS1, mS2, mLat;
  logic [2:0] mMode;
  logic mFlag, mGie, mPeie, mCie;

  function automatic logic mActive();
    return (mMode != 3'b000) && (mMode != 3'b111);
  endfunction
  function automatic logic [1:0] mLive();
    return mActive() ? mS2 : 2'b00;
  endfunction
  function automatic logic [7:0] expRd();
    if (!rdEn) return 8'h00;
    case (addr)
      2'd0: return {mLive(), 3'b000, mMode};
      2'd1: return {7'b0, mFlag};
      2'd2: return {mGie, mPeie, 6'b0};
      default: return {7'b0, mCie};
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= '0; mS2 <= '0; mLat <= '0; mMode <= '0;
      mFlag <= 0; mGie <= 0; mPeie <= 0; mCie <= 0;
    end else begin
      mS1 <= cmpRaw; mS2 <= mS1;
      if (wrEn && addr == 2'd0) mMode <= wrData[2:0];
      if (!mActive()) mLat <= '0;
      else if ((rdEn || wrEn) && addr == 2'd0) mLat <= mLive();
      if (mActive() && mLive() != mLat) mFlag <= 1'b1;
      else if (wrEn && addr == 2'd1) mFlag <= wrData[0];
      if (wrEn && addr == 2'd2) begin mGie <= wrData[7]; mPeie <= wrData[6]; end
      if (wrEn && addr == 2'd3) mCie <= wrData[0];
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelCompare();
    check("R2/R3 model rdData", rdData, expRd());
    check("R6 model irqReq", {7'b0, irqReq},
          {7'b0, mFlag & mCie & mPeie & mGie});
    check("R9 model wakeReq", {7'b0, wakeReq},
          {7'b0, sleepMode & mActive() & mFlag & mCie & mPeie});
    check("R8 model cmpPowerDown", {6'b0, cmpPowerDown},
          {6'b0, {2{~mActive()}}});
  endtask

  task automatic step(input logic [1:0] a, input logic r, input logic w, input logic [7:0] d);
    @(negedge clk);
    addr = a; rdEn = r; wrEn = w; wrData = d;
    #5;
    modelCompare();
  endtask

  task automatic idle(); step(2'd0, 1'b0, 1'b0, 8'h00); endtask

  initial begin
    void'($urandom(32'd1234));
    #1 rstN = 1'b0;
    #5;
    check("R7 power-down in reset", {6'b0, cmpPowerDown}, 8'h03);
    check("R7 no irq in reset", {7'b0, irqReq}, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    step(2'd0, 1, 0, 8'h00); check("R7 ctrl reset value", rdData, 8'h00);
    step(2'd1, 1, 0, 8'h00); check("R7 flag reset value", rdData, 8'h00);

    step(2'd3, 0, 1, 8'h01);
    step(2'd2, 0, 1, 8'hC0);
    step(2'd0, 0, 1, 8'h02);
    step(2'd0, 1, 0, 8'h00); check("R2 ctrl mode readback", rdData, 8'h02);

    // R1 latency
    @(negedge clk); cmpRaw = 2'b01;
    step(2'd1, 1, 0, 8'h00); check("R1 flag not yet set", rdData, 8'h00);
    step(2'd1, 1, 0, 8'h00); check("R1 flag still clear at 2nd edge", rdData, 8'h00);
    step(2'd1, 1, 0, 8'h00); check("R1 flag set at 3rd edge", rdData, 8'h01);
    check("R6 irq with all enables", {7'b0, irqReq}, 8'h01);

    // R4 / R11 clear while mismatch persists
    step(2'd1, 0, 1, 8'h00);
    step(2'd1, 1, 0, 8'h00); check("R4 R11 clear without touch ignored", rdData, 8'h01);

    // R3 touch then clear
    step(2'd0, 1, 0, 8'h00); check("R2 ctrl outputs in bit 6", rdData, 8'h42);
    step(2'd1, 0, 1, 8'h00);
    step(2'd1, 1, 0, 8'h00); check("R3 clear after touch sticks", rdData, 8'h00);
    check("R3 irq dropped", {7'b0, irqReq}, 8'h00);

    // R5 simulated interrupt
    step(2'd1, 0, 1, 8'h01);
    step(2'd1, 1, 0, 8'h00); check("R5 software set", rdData, 8'h01);
    check("R5 R6 irq from software set", {7'b0, irqReq}, 8'h01);

    // R6 / R9 global enable off
    step(2'd2, 0, 1, 8'h40);
    idle(); check("R6 irq gated by global", {7'b0, irqReq}, 8'h00);
    @(negedge clk); sleepMode = 1'b1;
    step(2'd1, 1, 0, 8'h00); check("R9 wake without global", {7'b0, wakeReq}, 8'h01);
    check("R6 flag holds with enable off", rdData, 8'h01);
    step(2'd0, 1, 0, 8'h00); check("R10 ctrl unchanged in sleep", rdData, 8'h42);
    @(negedge clk); sleepMode = 1'b0;
    step(2'd2, 1, 0, 8'h00); check("R10 enables unchanged after wake", rdData, 8'h40);

    // R8 off mode
    step(2'd0, 0, 1, 8'h07);
    step(2'd1, 0, 1, 8'h00);
    @(negedge clk); cmpRaw = 2'b10;
    repeat (4) idle();
    step(2'd1, 1, 0, 8'h00); check("R8 no flag when off", rdData, 8'h00);
    check("R8 powered down when off", {6'b0, cmpPowerDown}, 8'h03);
    step(2'd0, 1, 0, 8'h00); check("R8 outputs read 0 when off", rdData, 8'h07);
    step(2'd0, 0, 1, 8'h01);
    idle(); check("R8 powered up when active", {6'b0, cmpPowerDown}, 8'h00);

    // R11 hardware set and software clear in the same cycle
    step(2'd1, 0, 1, 8'h00);
    step(2'd1, 1, 0, 8'h00); check("R11 flag set by mismatch", rdData, 8'h01);

    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      @(negedge clk);
      if (rv[3:0] == 4'd0) cmpRaw = rv[5:4];
      if (rv[9:6] == 4'd0) sleepMode = rv[10];
      addr = rv[12:11];
      rdEn = rv[13];
      wrEn = rv[14] & rv[15];
      wrData = rv[23:16];
      #5;
      modelCompare();
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule